// File: doc/BRIEF.md
# Gain-Step Control Word Latch

This block keeps the six-bit gain-step setting of a digitally stepped amplifier and presents it as a registered attenuation code. The code counts in 0.5 dB steps, so code 0 is full gain and code 63 is 31.5 dB of attenuation. The six control bits reach the block active-low and binary-weighted. A mode input picks the control path. In parallel mode the word either tracks the six pins or is captured by a latch-enable pulse. In serial mode the word is clocked in one bit at a time and is applied only when latch enable rises.

Every input is asynchronous to the system clock. All of them pass through one shared synchronizer, and latch enable and the serial clock are edge-detected after it. After reset the block counts a programmable number of cycles with the output held at maximum attenuation. It then loads a start-up code. If latch enable is low at that moment, the code comes from a four-entry preset table indexed by two preset pins. If latch enable is high, the code comes from the parallel pins.

Each level of latch enable, serial clock and serial data must be held for at least `SYNC_STAGES + 1` system clocks. At 200 MHz the 100 ns serial-clock period and 630 ns latch-enable spacing that the controlling side guarantees meet this with margin. The output is a plain level that is always valid, so it has no handshake and no back-pressure.

Top module: `gain_word_latch`

## Requirements
- R1: From reset until `PUP_CYCLES` clock cycles after reset release, `atten` is 63 and every other input is ignored.
- R2: If `le` is low when the power-up count ends, `atten` loads from `preset` = {pin1,pin2}: 2'b00 gives 63, 2'b10 gives 48, 2'b01 gives 32, 2'b11 gives 0.
- R3: If `le` is high when the power-up count ends, `atten` loads the bitwise inverse of `ctrl_n`.
- R4: In parallel mode (`ser_sel` = 0) with `le` high, `atten` follows `~ctrl_n`, changing on the third rising clock edge after an input change.
- R5: In parallel mode with `le` low, `atten` holds its value whatever `ctrl_n` does.
- R6: A word set on `ctrl_n` while `le` is low is applied by a high pulse on `le` and is kept after `le` falls.
- R7: In serial mode (`ser_sel` = 1), each rising edge of `sclk` shifts in `sdata`. Six bits go in, the first being control bit 5 (MSB first). `atten` does not change while shifting.
- R8: In serial mode, a rising edge of `le` sets `atten` to the inverse of the last six shifted bits, and `ctrl_n` has no effect.
- R9: Control bit i is active-low with a weight of 2^i half-dB. `atten[i]` = `~ctrl_n[i]`: all ones gives 0, all zeros gives 63, and mixed words give the sum of the low bits.
- R10: Asserting `rst_n` at any time returns `atten` to 63 and restarts the power-up count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, restarts power-up |
| ser_sel | input | 1 | Mode select: 0 parallel, 1 serial |
| le | input | 1 | Latch enable |
| sclk | input | 1 | Serial shift clock |
| sdata | input | 1 | Serial data, MSB first |
| ctrl_n | input | 6 | Active-low parallel control word |
| preset | input | 2 | Power-up preset select {pin1,pin2} |
| atten | output | 6 | Attenuation code in 0.5 dB steps |

## Verification
Every input goes through two synchronizer stages before the output register. A change on the pins therefore reaches `atten` on the third rising edge, and the bench checks four cycles after each stimulus. Serial bits and clock levels are each held for four cycles, so every edge is seen cleanly. The start-up value is checked a few cycles before and a few cycles after the `PUP_CYCLES` boundary, never on the boundary edge itself.

// File: rtl/gwl_pkg.sv
package gwl_pkg;
  localparam int WORD_W = 6;
  typedef logic [WORD_W-1:0] code_t;
  localparam code_t MAX_ATTEN = '1;

  function automatic code_t preset_code(input logic [1:0] sel);
    case (sel)
      2'b00:   preset_code = MAX_ATTEN;
      2'b10:   preset_code = code_t'(48);
      2'b01:   preset_code = code_t'(32);
      default: preset_code = '0;
    endcase
  endfunction
endpackage

// File: rtl/gwl_sync.sv
module gwl_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gwl_por.sv
module gwl_por #(
  parameter int unsigned CYCLES = 40_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic done,
  output logic load
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  assign load = !done && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (load) begin
      done <= 1'b1;
    end else if (!done) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/gwl_shift.sv
module gwl_shift #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  word <= '1;
    else if (en) word <= {word[W-2:0], din};
  end
endmodule

// File: rtl/gain_word_latch.sv
module gain_word_latch
  import gwl_pkg::*;
#(
  parameter int unsigned PUP_CYCLES  = 40_000_000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_sel,
  input  logic              le,
  input  logic              sclk,
  input  logic              sdata,
  input  logic [WORD_W-1:0] ctrl_n,
  input  logic [1:0]        preset,
  output logic [WORD_W-1:0] atten
);
  localparam int BUS_W = WORD_W + 6;

  logic [BUS_W-1:0] bus_s;
  logic             ser_s, le_s, sclk_s, sdata_s;
  logic [1:0]       pre_s;
  code_t            ctrl_s;
  logic             le_q, sclk_q, le_rise, sclk_rise;
  logic             por_done, por_load;
  code_t            sr_word;

  gwl_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst_n,
    .d({ser_sel, le, sclk, sdata, preset, ctrl_n}),
    .q(bus_s)
  );

  assign {ser_s, le_s, sclk_s, sdata_s, pre_s, ctrl_s} = bus_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      le_q   <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      le_q   <= le_s;
      sclk_q <= sclk_s;
    end
  end

  assign le_rise   = le_s & ~le_q;
  assign sclk_rise = sclk_s & ~sclk_q;

  gwl_por #(.CYCLES(PUP_CYCLES)) u_por (
    .clk, .rst_n, .done(por_done), .load(por_load)
  );

  gwl_shift #(.W(WORD_W)) u_shift (
    .clk, .rst_n,
    .en(por_done & ser_s & sclk_rise),
    .din(sdata_s),
    .word(sr_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      atten <= MAX_ATTEN;
    end else if (por_load) begin
      atten <= le_s ? ~ctrl_s : preset_code(pre_s);
    end else if (por_done) begin
      if (!ser_s) begin
        if (le_s) atten <= ~ctrl_s;
      end else if (le_rise) begin
        atten <= ~sr_word;
      end
    end
  end
endmodule

// File: rtl/gwl_checker.sv
module gwl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       done,
  input logic       ser_s,
  input logic       le_s,
  input logic       le_rise,
  input logic [5:0] atten
);
  assert_hold_max_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> atten == 6'd63);

  assert_done_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  assert_latched_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ser_s && !le_s) |=> $stable(atten));

  assert_shift_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ser_s && !le_rise) |=> $stable(atten));
endmodule

bind gain_word_latch gwl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .done(por_done), .ser_s(ser_s),
  .le_s(le_s), .le_rise(le_rise), .atten(atten)
);

// File: tb/gain_word_latch_test.sv
module gain_word_latch_test;
  localparam int PUP = 50;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       ser_sel = 0, le = 0, sclk = 0, sdata = 0;
  logic [5:0] ctrl_n = '1;
  logic [1:0] preset = 2'b00;
  logic [5:0] atten;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  gain_word_latch #(.PUP_CYCLES(PUP), .SYNC_STAGES(2)) uut (
    .clk, .rst_n, .ser_sel, .le, .sclk, .sdata, .ctrl_n, .preset, .atten
  );

  localparam int NV = 10;
  localparam logic [11:0] VEC [NV] = '{
    {6'b111111, 6'd0},  {6'b111110, 6'd1},  {6'b111101, 6'd2},
    {6'b111011, 6'd4},  {6'b110111, 6'd8},  {6'b101111, 6'd16},
    {6'b011111, 6'd32}, {6'b000000, 6'd63}, {6'b101010, 6'd21},
    {6'b011110, 6'd33}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: atten=%0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    tick(2);
    check("R10 reset value", atten, 6'd63);
    rst_n = 1;
  endtask

  initial begin
    tick(1);
    // R2 / R10: each preset after a fresh reset
    for (int p = 0; p < 4; p++) begin
      logic [1:0] sel;
      logic [5:0] exp;
      sel = (p == 0) ? 2'b00 : (p == 1) ? 2'b10 : (p == 2) ? 2'b01 : 2'b11;
      exp = (p == 0) ? 6'd63 : (p == 1) ? 6'd48 : (p == 2) ? 6'd32 : 6'd0;
      le = 0; preset = sel; ctrl_n = 6'b010101;
      do_reset();
      tick(PUP - 4);
      check("R1 held before delay", atten, 6'd63);
      tick(8);
      check("R2 preset default", atten, exp);
    end

    // R3: le high at power-up takes the parallel word
    le = 1; ctrl_n = 6'b110010; preset = 2'b11;
    do_reset();
    tick(10);
    ctrl_n = 6'b000000;
    tick(6);
    check("R1 inputs ignored during delay", atten, 6'd63);
    ctrl_n = 6'b110010;
    tick(PUP);
    check("R3 parallel default", atten, 6'd13);

    // R4 / R9: direct parallel table
    for (int i = 0; i < NV; i++) begin
      ctrl_n = VEC[i][11:6];
      tick(4);
      check("R4/R9 direct follow", atten, VEC[i][5:0]);
    end

    // R5 / R6: latched parallel
    ctrl_n = 6'b111111; tick(4);
    le = 0; tick(4);
    ctrl_n = 6'b000000; tick(8);
    check("R5 hold while le low", atten, 6'd0);
    le = 1; tick(4); le = 0; tick(4);
    check("R6 pulse applies word", atten, 6'd63);
    ctrl_n = 6'b101111; tick(8);
    check("R6 kept after le falls", atten, 6'd63);

    // R7 / R8: serial, word 100101 MSB first -> atten 26
    ser_sel = 1; tick(4);
    for (int b = 5; b >= 0; b--) begin
      logic [5:0] w;
      w = 6'b100101;
      sdata = w[b]; tick(4);
      sclk = 1; tick(4);
      sclk = 0;
      ctrl_n = ~ctrl_n; tick(4);
      check("R7 no change while shifting", atten, 6'd63);
    end
    le = 1; tick(4);
    check("R8 le rise applies serial word", atten, 6'd26);
    ctrl_n = 6'b000000; tick(6);
    check("R8 ctrl_n ignored in serial", atten, 6'd26);
    le = 0; tick(4);
    check("R8 holds after le falls", atten, 6'd26);

    // R10: reset mid-operation
    rst_n = 0; tick(1);
    check("R10 reset mid-run", atten, 6'd63);
    rst_n = 1; ser_sel = 0; le = 0; preset = 2'b01;
    tick(PUP - 4);
    check("R10 delay restarted", atten, 6'd63);
    tick(8);
    check("R10/R2 preset after restart", atten, 6'd32);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: atten=%0d expected completion", atten);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule